// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupts

A bank of up to 32 general-purpose pins behind a plain word-addressed register port. Software sets, per pin, the value to drive, whether the pin is an input or an output, whether an output blinks on its own, and whether the pin's sense is inverted. Input pins are resynchronised to the bank clock and can be read back through a data-in register that already reflects the inversion.

Each pin can raise an interrupt in two ways. An edge detector latches a cause bit whenever the synchronised, sense-adjusted input goes from 0 to 1; software clears cause bits by writing zeros. A level path passes the adjusted input itself. Two processor cores each own an edge-mask and level-mask pair. Each core has its own interrupt line, which is high when any pin enabled by that core's masks is pending. Both-edge operation is obtained by software flipping a pin's sense bit after each caught edge.

Top module: `gpio_bank`

## Requirements
- R1: Reset makes every pin an output (`pin_oe` all ones) driving 0, clears every register so that each reads 0, and holds both interrupt lines low.
- R2: Byte offsets from the bank base: 0x00 output value, 0x04 direction, 0x08 blink enable, 0x0C sense inversion, 0x10 data in (read-only), 0x14 edge cause, 0x18 and 0x1C edge and level masks of core 0, 0x30 and 0x34 edge and level masks of core 1. Each writable register reads back what was written. Unmapped offsets read 0.
- R3: A direction bit of 1 makes the pin an input (`pin_oe` bit low). A 0 makes it an output (`pin_oe` bit high) driven from the output-value register.
- R4: Data in reads the pin after a two-flop synchronizer, XOR the sense-inversion bit. A pin change shows up after the second rising clock edge, and writes to offset 0x10 have no effect.
- R5: A cause bit is set on the clock edge after the adjusted input rises from 0 to 1, which is one edge after it appears in data in. With the inversion bit at 1 a falling pin is caught, and a cause bit never sets without such a rise.
- R6: Writing the cause register clears every bit written as 0 and keeps every bit written as 1.
- R7: When an edge and a clearing write hit the same cause bit on the same clock edge, the bit ends up set.
- R8: Each core's interrupt is the OR over pins of (data in AND its level mask) OR (cause AND its edge mask). It uses only that core's own masks.
- R9: Setting a pin's inversion bit after a rising edge has been caught, then clearing its cause, lets the following falling edge set the cause again.
- R10: A write to the blink register restarts the shared prescaler with the blink phase low, and clears the output-value bit of each newly enabled pin. Such a pin is driven low at once, then toggles every BLINK_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Value driven on each pin |
| pin_oe | output | NPINS | Output enable per pin, 1 = driving |
| irq_core0 | output | 1 | Interrupt line for core 0 |
| irq_core1 | output | 1 | Interrupt line for core 1 |

## Verification
The bench reads data in and cause one edge before each is due. A design with one synchronizer flop too few or too many fails there, and so does one that sets the cause on the same edge as data in. It lands a clearing write on exactly the edge where a new rise arrives, which catches a design that lets the clear win. It drives a pin whose cause is pending while only the other core's masks select it, which exposes masks shared between the cores. It also follows a blinking pin through two full periods, which shows whether the prescaler really restarts and whether the pin starts low.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NPINS     = 32,
  parameter int BLINK_DIV = 1024,
  localparam int CW       = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [5:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_core0,
  output logic             irq_core1
);
  localparam logic [5:0] A_OUT = 6'h00, A_DIR = 6'h04, A_BLINK = 6'h08, A_INV = 6'h0C;
  localparam logic [5:0] A_DIN = 6'h10, A_CAUSE = 6'h14;
  localparam logic [5:0] A_EM0 = 6'h18, A_LM0 = 6'h1C, A_EM1 = 6'h30, A_LM1 = 6'h34;
  localparam logic [CW-1:0] CNT_LAST = CW'(BLINK_DIV - 1);

  logic [NPINS-1:0] out_q, dir_q, blink_q, inv_q, cause_q;
  logic [NPINS-1:0] em0_q, lm0_q, em1_q, lm1_q;
  logic [NPINS-1:0] sync1_q, sync2_q, adj_q;
  logic [NPINS-1:0] adj, rise, wd, cause_kept, rsel;
  logic [CW-1:0]    cnt_q;
  logic             phase_q;
  logic             wr_blink;

  assign wd       = bus_wdata[NPINS-1:0];
  assign adj      = sync2_q ^ inv_q;
  assign rise     = adj & ~adj_q;
  assign wr_blink = bus_we && (bus_addr == A_BLINK);
  assign cause_kept = (bus_we && bus_addr == A_CAUSE) ? (cause_q & wd) : cause_q;

  assign pin_oe    = ~dir_q;
  assign pin_out   = out_q ^ (blink_q & {NPINS{phase_q}});
  assign irq_core0 = |((adj & lm0_q) | (cause_q & em0_q));
  assign irq_core1 = |((adj & lm1_q) | (cause_q & em1_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0; dir_q <= '0; blink_q <= '0; inv_q <= '0; cause_q <= '0;
      em0_q <= '0; lm0_q <= '0; em1_q <= '0; lm1_q <= '0;
      sync1_q <= '0; sync2_q <= '0; adj_q <= '0;
      cnt_q <= '0; phase_q <= 1'b0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      adj_q   <= adj;
      cause_q <= cause_kept | rise;
      if (bus_we && bus_addr == A_OUT) out_q <= wd;
      else if (wr_blink)               out_q <= out_q & ~(wd & ~blink_q);
      if (bus_we && bus_addr == A_DIR) dir_q <= wd;
      if (wr_blink)                    blink_q <= wd;
      if (bus_we && bus_addr == A_INV) inv_q <= wd;
      if (bus_we && bus_addr == A_EM0) em0_q <= wd;
      if (bus_we && bus_addr == A_LM0) lm0_q <= wd;
      if (bus_we && bus_addr == A_EM1) em1_q <= wd;
      if (bus_we && bus_addr == A_LM1) lm1_q <= wd;
      if (wr_blink) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_OUT:   rsel = out_q;
      A_DIR:   rsel = dir_q;
      A_BLINK: rsel = blink_q;
      A_INV:   rsel = inv_q;
      A_DIN:   rsel = adj;
      A_CAUSE: rsel = cause_q;
      A_EM0:   rsel = em0_q;
      A_LM0:   rsel = lm0_q;
      A_EM1:   rsel = em1_q;
      A_LM1:   rsel = lm1_q;
      default: rsel = '0;
    endcase
    bus_rdata = '0;
    bus_rdata[NPINS-1:0] = rsel;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pin_oe == '1 && pin_out == '0 && !irq_core0 && !irq_core1));

  p_cause_needs_edge_r5: assert property (@(posedge clk) disable iff (rst)
    ((cause_q & ~$past(cause_q) & ~$past(rise)) == '0));

  p_edge_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (($past(rise) & ~cause_q) == '0));

  p_irq_quiet_unmasked_r8: assert property (@(posedge clk) disable iff (rst)
    (em0_q == '0 && lm0_q == '0) |-> !irq_core0);

  p_blink_starts_low_r10: assert property (@(posedge clk) disable iff (rst)
    $past(wr_blink) |-> ((pin_out & blink_q & ~$past(blink_q)) == '0));
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int NP = 32;
  logic clk = 1'b0, rst = 1'b1, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq_core0, irq_core1;
  int errors = 0, checks = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  gpio_bank #(.NPINS(NP), .BLINK_DIV(4)) u_gpio_bank (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_core0(irq_core0), .irq_core1(irq_core1));

  // {offset, write value, expected readback}
  localparam logic [69:0] TBL [8] = '{
    {6'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {6'h04, 32'h1234_5678, 32'h1234_5678},
    {6'h0C, 32'h0000_FFFF, 32'h0000_FFFF},
    {6'h18, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {6'h1C, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
    {6'h30, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {6'h34, 32'h00FF_00FF, 32'h00FF_00FF},
    {6'h10, 32'hFFFF_FFFF, 32'h0000_FFFF}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; pin_in = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pin_oe", pin_oe, '1);
    chk("R1 pin_out", pin_out, '0);
    chk("R1 irqs", {30'd0, irq_core1, irq_core0}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      rd(TBL[i][69:64], v);
      chk("R1 register zero", v, 32'd0);
    end

    // R2 register map walk
    for (int i = 0; i < 8; i++) begin
      wr(TBL[i][69:64], TBL[i][63:32]);
      rd(TBL[i][69:64], v);
      chk("R2 readback", v, TBL[i][31:0]);
    end
    rd(6'h20, v);
    chk("R2 unmapped", v, 32'd0);

    do_reset();
    // R3 direction
    wr(6'h04, 32'h0000_00F0);
    wr(6'h00, 32'h0000_0033);
    chk("R3 pin_oe", pin_oe, 32'hFFFF_FF0F);
    chk("R3 pin_out", pin_out, 32'h0000_0033);

    // R4 / R5 synchronizer and edge timing
    @(negedge clk); pin_in = 32'h0000_0101;
    @(negedge clk);
    rd(6'h10, v); chk("R4 data in after one edge", v, 32'd0);
    @(negedge clk);
    rd(6'h10, v); chk("R4 data in after two edges", v, 32'h0000_0101);
    rd(6'h14, v); chk("R5 cause not yet", v, 32'd0);
    @(negedge clk);
    rd(6'h14, v); chk("R5 cause set", v, 32'h0000_0101);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, v); chk("R4 data in write ignored", v, 32'h0000_0101);

    // R6 clear by zero
    wr(6'h14, 32'hFFFF_FFFE);
    rd(6'h14, v); chk("R6 clear bit0 keep bit8", v, 32'h0000_0100);

    // R8 per-core masks
    wr(6'h1C, 32'h0000_0100);
    chk("R8 core0 level", {31'd0, irq_core0}, 32'd1);
    chk("R8 core1 unaffected", {31'd0, irq_core1}, 32'd0);
    wr(6'h1C, 32'h0);
    wr(6'h30, 32'h0000_0100);
    chk("R8 core1 edge", {31'd0, irq_core1}, 32'd1);
    chk("R8 core0 own masks only", {31'd0, irq_core0}, 32'd0);
    wr(6'h14, 32'h0);
    chk("R8 core1 cleared", {31'd0, irq_core1}, 32'd0);
    wr(6'h30, 32'h0);

    // R5 falling edge via inversion
    wr(6'h0C, 32'h0000_0001);
    rd(6'h14, v); chk("R5 inversion alone no edge", v, 32'd0);
    @(negedge clk); pin_in = 32'h0000_0100;
    repeat (3) @(negedge clk);
    rd(6'h14, v); chk("R5 falling caught", v, 32'h0000_0001);
    rd(6'h10, v); chk("R4 inverted data in", v, 32'h0000_0101);
    wr(6'h14, 32'h0);

    // R9 both edges on pin 2
    @(negedge clk); pin_in = 32'h0000_0104;
    repeat (3) @(negedge clk);
    rd(6'h14, v); chk("R9 rising caught", v, 32'h0000_0004);
    wr(6'h0C, 32'h0000_0005);
    wr(6'h14, 32'h0);
    rd(6'h14, v); chk("R9 flip adds no edge", v, 32'd0);
    @(negedge clk); pin_in = 32'h0000_0100;
    repeat (3) @(negedge clk);
    rd(6'h14, v); chk("R9 falling caught", v, 32'h0000_0004);

    // R7 edge and clear on the same edge
    @(negedge clk); pin_in = 32'h0000_0108;
    @(negedge clk);
    wr(6'h14, 32'h0);
    rd(6'h14, v); chk("R7 edge wins over clear", v, 32'h0000_0008);

    // R10 blink
    wr(6'h08, 32'h0000_0010);
    chk("R10 starts low", pin_out, 32'h0000_0023);
    rd(6'h00, v); chk("R10 output bit cleared", v, 32'h0000_0023);
    repeat (3) @(negedge clk);
    chk("R10 still low", pin_out, 32'h0000_0023);
    @(negedge clk);
    chk("R10 high after period", pin_out, 32'h0000_0033);
    repeat (4) @(negedge clk);
    chk("R10 low again", pin_out, 32'h0000_0023);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule